// File: doc/BRIEF.md
# Message and level interrupt source controller

This block holds the per-source state of a group of interrupt inputs and hands interrupts, one at a time, to a presentation unit further along the chip. A strap gives each input a type. A message (edge) source fires on a rising edge of its input. A level source follows its input line. Each source has a destination server and a priority, both set through a configuration-write port. The all-ones priority masks the source. An interrupt leaves the block as a global number, which is the source index plus a fixed base, together with its server and priority.

The presentation unit answers with three plain pulses. A reject returns an interrupt it could not take. An EOI ends service of an interrupt. A resend asks the block to offer again whatever is still owed. Reject and EOI carry a global number, which the block matches against its own range; a number outside that range is ignored. A resend starts a scan in ascending source order. The scan visits one source per cycle and waits while an offer is held in the output register or a request is waiting to enter it.

Offers use a valid/ready stream. Once `offer_valid` is high, the number, server and priority stay unchanged until the cycle in which `offer_ready` is high. The offer is consumed in that cycle. When several sources are waiting, the lowest index goes first. A request that is waiting but has not reached the output register is withdrawn if its source is masked before it is presented.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no offer is valid and every source is masked (priority all ones). An input that is high through reset produces no offer.
- R2: A rising edge on an unmasked message source produces one offer. Its number is BASE plus the source index (0x1000 plus index by default), and it carries the source's current server and priority.
- R3: A message source that fires while masked is remembered as masked-pending and is not offered. A later configuration write that unmasks it clears masked-pending and offers it once.
- R4: A level source whose line is high and that is unmasked is offered once and marked sent. While the line stays high and the source is still marked sent, it is not offered again.
- R5: A reject naming a message source marks it rejected. The next resend clears that mark and offers the source again. A resend with no rejected source produces no offer.
- R6: A reject naming a level source clears its sent mark. A resend then offers it again if its line is still high, and produces no offer if the line has fallen.
- R7: An EOI naming a level source clears its sent mark, so the next resend offers it again while the line is high. An EOI naming a message source has no effect, and a following resend does not offer it.
- R8: A reject or EOI whose number lies outside BASE to BASE+NUM_SRC-1 changes no source.
- R9: While offer_valid is high and offer_ready is low, the offer fields hold steady. Sources waiting together are offered in ascending index order, and a resend scan re-offers in ascending index order.
- R10: Masking a source whose request has not yet reached the output register withdraws that request. A message source then becomes masked-pending and is offered once unmasked. No valid offer ever carries the all-ones priority.
- R11: A configuration write that unmasks a level source whose line is high offers that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_is_level | input | NUM_SRC | Per-source type strap: 1 for level, 0 for message |
| irq_in | input | NUM_SRC | Interrupt inputs. Message sources fire on a rising edge; level sources follow the line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index to configure |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority; all ones masks the source |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | The presentation unit takes the offer in this cycle |
| offer_num | output | NUM_W | Global interrupt number of the offer |
| offer_server | output | SRV_W | Server of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |
| rej_valid | input | 1 | Reject pulse |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | NUM_W | Global number being ended |
| resend_req | input | 1 | Starts a resend scan over all sources |

## Verification
The bench targets the ways the two source types differ. A design that mixed up the rules would re-offer a message source after an EOI, or would leave a level source silent after a reject followed by a resend. The bench also checks status that must persist across masking. A design that lost masked-pending would never deliver an edge that arrived while masked. A design that did not withdraw a waiting request on masking would present an offer with the masked priority. The bench further holds the stream stalled and sends reject and EOI numbers just outside the block's range. A wrong design would change the offer while it is stalled, or would free a sent level source on a number that is not its own.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  // Per-source status flags
  typedef struct packed {
    logic asserted;  // level: registered line value
    logic sent;      // level: offered and not yet ended or returned
    logic rejected;  // message: returned, owed on the next resend
    logic mpend;     // message: fired (or withdrawn) while masked
    logic req;       // waiting to enter the offer register
  } src_stat_t;
endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
  import irqsrc_pkg::*;
#(
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_lvl,
  input  logic              line,
  input  logic              grant,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              visit,
  output logic              req,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio
);
  localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

  src_stat_t         st, st_n;
  logic [SRV_W-1:0]  srv_n;
  logic [PRIO_W-1:0] prio_n;
  logic              line_q;
  logic              unmasked;
  logic              check;

  always_comb begin
    st_n     = st;
    srv_n    = server;
    prio_n   = prio;
    check    = 1'b0;
    if (grant) st_n.req = 1'b0;
    if (cfg_hit) begin
      srv_n  = cfg_server;
      prio_n = cfg_prio;
    end
    unmasked = (prio_n != MASKED);
    if (is_lvl) begin
      if (rej_hit || eoi_hit) st_n.sent = 1'b0;
      if (line != st.asserted) begin
        st_n.asserted = line;
        check         = 1'b1;
      end
      if (cfg_hit || visit) check = 1'b1;
      if (st_n.req && !unmasked) begin
        st_n.req  = 1'b0;
        st_n.sent = 1'b0;
      end
      if (check && unmasked && st_n.asserted && !st_n.sent) begin
        st_n.sent = 1'b1;
        st_n.req  = 1'b1;
      end
    end else begin
      if (rej_hit) st_n.rejected = 1'b1;
      if (st_n.req && !unmasked) begin
        st_n.req   = 1'b0;
        st_n.mpend = 1'b1;
      end
      if (line && !line_q) begin
        if (unmasked) st_n.req = 1'b1;
        else          st_n.mpend = 1'b1;
      end
      if (cfg_hit && st_n.mpend && unmasked) begin
        st_n.mpend = 1'b0;
        st_n.req   = 1'b1;
      end
      if (visit && st_n.rejected) begin
        st_n.rejected = 1'b0;
        if (unmasked) st_n.req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= '0;
      server <= '0;
      prio   <= MASKED;
      line_q <= 1'b0;
    end else begin
      st     <= st_n;
      server <= srv_n;
      prio   <= prio_n;
      line_q <= line;
    end
  end

  assign req = st.req;
endmodule

// File: rtl/irqsrc_offer.sv
module irqsrc_offer #(
  parameter int           NUM_SRC = 8,
  parameter int           SRV_W   = 8,
  parameter int           PRIO_W  = 8,
  parameter int           NUM_W   = 16,
  parameter logic [NUM_W-1:0] BASE = 16'h1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0][SRV_W-1:0] srv_arr,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr,
  input  logic                          ready,
  output logic [NUM_SRC-1:0]            gnt,
  output logic                          valid,
  output logic [NUM_W-1:0]              num,
  output logic [SRV_W-1:0]              srv,
  output logic [PRIO_W-1:0]             prio
);
  logic [NUM_SRC-1:0] first;
  logic [NUM_W-1:0]   pick_num;
  logic [SRV_W-1:0]   pick_srv;
  logic [PRIO_W-1:0]  pick_prio;
  logic               found;
  logic               load;

  always_comb begin
    first     = '0;
    found     = 1'b0;
    pick_num  = BASE;
    pick_srv  = '0;
    pick_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !found) begin
        found     = 1'b1;
        first[i]  = 1'b1;
        pick_num  = BASE + NUM_W'(i);
        pick_srv  = srv_arr[i];
        pick_prio = prio_arr[i];
      end
    end
  end

  assign load = found && (!valid || ready);
  assign gnt  = load ? first : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      num   <= '0;
      srv   <= '0;
      prio  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      num   <= pick_num;
      srv   <= pick_srv;
      prio  <= pick_prio;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step_ok,
  output logic [NUM_SRC-1:0] visit,
  output logic               busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic [IDX_W-1:0] ptr;
  logic             step;

  assign step = busy && step_ok;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      visit[i] = step && (ptr == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (step) begin
      if (ptr == LAST) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int           NUM_SRC = 8,
  parameter int           SRV_W   = 8,
  parameter int           PRIO_W  = 8,
  parameter int           NUM_W   = 16,
  parameter logic [NUM_W-1:0] BASE = 16'h1000,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_is_level,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRIO_W-1:0]  cfg_prio,
  output logic               offer_valid,
  input  logic               offer_ready,
  output logic [NUM_W-1:0]   offer_num,
  output logic [SRV_W-1:0]   offer_server,
  output logic [PRIO_W-1:0]  offer_prio,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req
);
  logic [NUM_SRC-1:0]             req;
  logic [NUM_SRC-1:0]             gnt;
  logic [NUM_SRC-1:0]             visit;
  logic [NUM_SRC-1:0][SRV_W-1:0]  srv_arr;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
  logic                           scan_busy;
  logic                           step_ok;

  assign step_ok = !offer_valid && !(|req);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic rej_hit, eoi_hit, cfg_hit;
    // Global number equals index plus BASE; anything else misses every slot
    assign rej_hit = rej_valid && (rej_num == (BASE + NUM_W'(g)));
    assign eoi_hit = eoi_valid && (eoi_num == (BASE + NUM_W'(g)));
    assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(g));

    irqsrc_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_lvl     (src_is_level[g]),
      .line       (irq_in[g]),
      .grant      (gnt[g]),
      .rej_hit    (rej_hit),
      .eoi_hit    (eoi_hit),
      .cfg_hit    (cfg_hit),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .visit      (visit[g]),
      .req        (req[g]),
      .server     (srv_arr[g]),
      .prio       (prio_arr[g])
    );
  end

  irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (resend_req),
    .step_ok (step_ok),
    .visit   (visit),
    .busy    (scan_busy)
  );

  irqsrc_offer #(
    .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W),
    .NUM_W(NUM_W), .BASE(BASE)
  ) u_offer (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .srv_arr  (srv_arr),
    .prio_arr (prio_arr),
    .ready    (offer_ready),
    .gnt      (gnt),
    .valid    (offer_valid),
    .num      (offer_num),
    .srv      (offer_server),
    .prio     (offer_prio)
  );

  logic unused_busy;
  assign unused_busy = scan_busy;
endmodule

// File: rtl/irqsrc_chk.sv
module irqsrc_chk #(
  parameter int           NUM_SRC = 8,
  parameter int           SRV_W   = 8,
  parameter int           PRIO_W  = 8,
  parameter int           NUM_W   = 16,
  parameter logic [NUM_W-1:0] BASE = 16'h1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               offer_valid,
  input logic               offer_ready,
  input logic [NUM_W-1:0]   offer_num,
  input logic [SRV_W-1:0]   offer_server,
  input logic [PRIO_W-1:0]  offer_prio,
  input logic [NUM_SRC-1:0] gnt
);
  localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};
  localparam logic [NUM_W-1:0]  TOP    = BASE + NUM_W'(NUM_SRC);

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> !offer_valid); // R1

  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_num >= BASE) && (offer_num < TOP)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
      && $stable(offer_server) && $stable(offer_prio)); // R9

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R9

  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (!offer_valid || offer_ready)); // R9

  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_prio != MASKED)); // R10
endmodule

bind irq_source_ctrl irqsrc_chk #(
  .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W),
  .NUM_W(NUM_W), .BASE(BASE)
) u_chk (.*);

// File: tb/sim_irq_source_ctrl.sv
`timescale 1ns/1ps
module sim_irq_source_ctrl;
  localparam logic [7:0]  LVL  = 8'hF0;  // sources 4..7 level, 0..3 message
  localparam logic [15:0] BASE = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = 8'h80;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [7:0]  cfg_server = '0, cfg_prio = '0;
  logic        offer_valid, offer_ready = 1'b0;
  logic [15:0] offer_num;
  logic [7:0]  offer_server, offer_prio;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
  logic [15:0] rej_num = '0, eoi_num = '0;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_source_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_is_level(LVL), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_num(offer_num), .offer_server(offer_server), .offer_prio(offer_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
    .eoi_num(eoi_num), .resend_req(resend_req)
  );

  // {index, server, priority}
  localparam logic [23:0] VEC [7] = '{
    {8'd0, 8'h01, 8'h10}, {8'd1, 8'h02, 8'h20}, {8'd2, 8'h03, 8'h00},
    {8'd3, 8'h04, 8'hFE}, {8'd4, 8'h05, 8'h30}, {8'd5, 8'h06, 8'h40},
    {8'd6, 8'h07, 8'h50}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] i, input logic [7:0] s, p);
    cfg_we = 1'b1; cfg_idx = i; cfg_server = s; cfg_prio = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = irq_in | m;
    @(negedge clk);
    irq_in = irq_in & ~m;
  endtask

  task automatic reject(input logic [15:0] n);
    rej_valid = 1'b1; rej_num = n;
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input logic [15:0] n);
    eoi_valid = 1'b1; eoi_num = n;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic resend();
    resend_req = 1'b1;
    @(negedge clk);
    resend_req = 1'b0;
  endtask

  task automatic take(input logic [15:0] en, input logic [7:0] es, ep, input string tag);
    int w;
    w = 0;
    while (!offer_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(offer_valid, {tag, " offer_valid"}, 32'(offer_valid), 1);
    if (offer_valid) begin
      chk(offer_num == en, {tag, " offer_num"}, 32'(offer_num), 32'(en));
      chk(offer_server == es, {tag, " offer_server"}, 32'(offer_server), 32'(es));
      chk(offer_prio == ep, {tag, " offer_prio"}, 32'(offer_prio), 32'(ep));
      offer_ready = 1'b1;
      @(negedge clk);
      offer_ready = 1'b0;
    end
  endtask

  task automatic none(input int n, input string tag);
    bit seen;
    logic [15:0] got;
    seen = 1'b0;
    got = '0;
    repeat (n) begin
      @(negedge clk);
      if (offer_valid && !seen) begin
        seen = 1'b1;
        got = offer_num;
      end
    end
    chk(!seen, {tag, " unexpected offer"}, 32'(got), 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    chk(!offer_valid, "R1 reset valid", 32'(offer_valid), 0);
    none(16, "R1 masked level high through reset");

    // Table walk: R2 for message sources, R4 for level sources
    for (int k = 0; k < 7; k++) begin
      logic [2:0] i;
      logic [7:0] s, p;
      i = VEC[k][18:16];
      s = VEC[k][15:8];
      p = VEC[k][7:0];
      cfg(i, s, p);
      if (LVL[i]) begin
        irq_in[i] = 1'b1;
        take(BASE + 16'(i), s, p, "R4 level offer");
        none(16, "R4 no re-offer while high");
        irq_in[i] = 1'b0;
        tick(2);
        eoi(BASE + 16'(i));
      end else begin
        pulse(8'(1) << i);
        take(BASE + 16'(i), s, p, "R2 message offer");
        none(8, "R2 single offer per edge");
      end
    end

    // R3: masked-pending message source
    cfg(3'd2, 8'h03, 8'hFF);
    pulse(8'h04);
    none(12, "R3 masked fire held");
    cfg(3'd2, 8'h03, 8'h10);
    take(16'h1002, 8'h03, 8'h10, "R3 unmask offers");
    none(12, "R3 offered once");

    // R5: message reject and resend
    pulse(8'h02);
    take(16'h1001, 8'h02, 8'h20, "R5 first offer");
    reject(16'h1001);
    none(8, "R5 reject alone");
    resend();
    take(16'h1001, 8'h02, 8'h20, "R5 resend re-offer");
    resend();
    none(20, "R5 resend nothing owed");

    // R6: level reject
    irq_in[4] = 1'b1;
    take(16'h1004, 8'h05, 8'h30, "R6 level offer");
    reject(16'h1004);
    none(6, "R6 reject alone");
    resend();
    take(16'h1004, 8'h05, 8'h30, "R6 resend line high");
    reject(16'h1004);
    irq_in[4] = 1'b0;
    tick(2);
    resend();
    none(20, "R6 resend line low");

    // R7: EOI on level and on message
    irq_in[5] = 1'b1;
    take(16'h1005, 8'h06, 8'h40, "R7 level offer");
    eoi(16'h1005);
    none(6, "R7 eoi alone");
    resend();
    take(16'h1005, 8'h06, 8'h40, "R7 resend after eoi");
    eoi(16'h1005);
    irq_in[5] = 1'b0;
    tick(2);
    pulse(8'h01);
    take(16'h1000, 8'h01, 8'h10, "R7 message offer");
    eoi(16'h1000);
    resend();
    none(20, "R7 eoi no effect on message");

    // R8: out-of-range numbers
    irq_in[6] = 1'b1;
    take(16'h1006, 8'h07, 8'h50, "R8 level offer");
    reject(16'h1008);
    eoi(16'h0FFF);
    resend();
    none(20, "R8 out-of-range ignored");
    eoi(16'h1006);
    resend();
    take(16'h1006, 8'h07, 8'h50, "R8 in-range eoi works");
    eoi(16'h1006);
    irq_in[6] = 1'b0;
    tick(2);

    // R9: stall stability and ascending order
    pulse(8'h09);
    tick(3);
    chk(offer_valid && offer_num == 16'h1000, "R9 lowest first", 32'(offer_num), 32'h1000);
    tick(4);
    chk(offer_valid && offer_num == 16'h1000, "R9 held while stalled", 32'(offer_num), 32'h1000);
    take(16'h1000, 8'h01, 8'h10, "R9 first");
    take(16'h1003, 8'h04, 8'hFE, "R9 second");
    pulse(8'h08);
    take(16'h1003, 8'h04, 8'hFE, "R9 scan setup 3");
    reject(16'h1003);
    pulse(8'h02);
    take(16'h1001, 8'h02, 8'h20, "R9 scan setup 1");
    reject(16'h1001);
    resend();
    take(16'h1001, 8'h02, 8'h20, "R9 scan order first");
    take(16'h1003, 8'h04, 8'hFE, "R9 scan order second");

    // R10: masking withdraws a waiting request
    pulse(8'h01);
    tick(3);
    pulse(8'h04);
    tick(1);
    cfg(3'd2, 8'h03, 8'hFF);
    take(16'h1000, 8'h01, 8'h10, "R10 held offer");
    none(16, "R10 withdrawn");
    cfg(3'd2, 8'h03, 8'h20);
    take(16'h1002, 8'h03, 8'h20, "R10 unmask delivers");

    // R11: unmask of a high level source
    cfg(3'd7, 8'h09, 8'h05);
    take(16'h1007, 8'h09, 8'h05, "R11 cfg check offers");
    none(12, "R11 offered once");

    summary();
    $finish;
  end
endmodule